// File: doc/BRIEF.md
# Lane Width Narrow/Widen Converter

This block sits in a vector datapath that normally moves eight 32-bit lanes per beat, in front of and behind the floating-point and reduction stages, which work on four lanes per beat. It has two independent paths. The narrowing path takes an eight-lane beat and produces four-lane beats. In split mode each wide beat becomes two narrow beats, so no data is lost and the path runs at half rate. In trim mode only the low half is kept, at full rate. The widening path does the reverse. In concatenate mode two consecutive narrow beats are joined into one wide beat. In pad mode a narrow beat is extended with four invalid, zeroed lanes.

Every lane carries its data word, a valid bit and a small tag, and all three move together. Both paths use valid/ready handshakes on both sides and register their output, so an accepted beat shows up at the output one cycle later. A typical pairing is split followed by concatenate, or trim followed by pad. Either pairing gives back the original wide layout once the four-lane work is done.

Top module: `lanewidth_conv`

## Requirements
- R1: After reset, `n_out_valid` and `w_out_valid` are low, and `w_in_ready` and `n_in_ready` are high.
- R2: With `nar_mode`=0 (split), an accepted wide beat produces two narrow beats. The first carries wide lanes 0..3 and the second carries wide lanes 4..7, each with its own data, valid bit and tag.
- R3: With `nar_mode`=1 (trim), an accepted wide beat produces exactly one narrow beat carrying wide lanes 0..3, and lanes 4..7 are dropped. With the output ready, the path accepts one wide beat every cycle.
- R4: In split mode `w_in_ready` stays low while the lower half is on the output. Under a continuous stream with the output always ready, one wide beat is accepted every two cycles.
- R5: With `wid_mode`=0 (concatenate), the first narrow beat of a pair produces no output. The second beat produces one wide beat: lanes 0..3 come from the first beat and lanes 4..7 from the second.
- R6: With `wid_mode`=1 (pad), a narrow beat produces one wide beat. Lanes 0..3 equal the input. Lanes 4..7 have data 0, tag 0 and valid bit 0.
- R7: The mode is sampled only when a beat starts a new unit of work. A narrowing mode change while a split is in progress does not stop the upper half from being sent. A narrow beat that arrives while a first half is held always completes the pair, whatever `wid_mode` is.
- R8: When an output is valid and its ready is low, the output stays valid with all lane fields stable. Input ready falls whenever accepting a beat would need the blocked output.
- R9: A beat that completes a unit of work appears on the output in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nar_mode | input | 1 | Narrowing mode: 0 split, 1 trim |
| w_in_valid | input | 1 | Wide input beat valid |
| w_in_ready | output | 1 | Wide input beat accepted when high with valid |
| w_in_data | input | 256 | Wide input data, lane i at bits 32i+31..32i |
| w_in_lv | input | 8 | Wide input per-lane valid, bit i for lane i |
| w_in_tag | input | 32 | Wide input per-lane tag, lane i at bits 4i+3..4i |
| n_out_valid | output | 1 | Narrow output beat valid |
| n_out_ready | input | 1 | Narrow output consumer ready |
| n_out_data | output | 128 | Narrow output data, lane i at bits 32i+31..32i |
| n_out_lv | output | 4 | Narrow output per-lane valid |
| n_out_tag | output | 16 | Narrow output per-lane tag |
| wid_mode | input | 1 | Widening mode: 0 concatenate, 1 pad |
| n_in_valid | input | 1 | Narrow input beat valid |
| n_in_ready | output | 1 | Narrow input beat accepted when high with valid |
| n_in_data | input | 128 | Narrow input data |
| n_in_lv | input | 4 | Narrow input per-lane valid |
| n_in_tag | input | 16 | Narrow input per-lane tag |
| w_out_valid | output | 1 | Wide output beat valid |
| w_out_ready | input | 1 | Wide output consumer ready |
| w_out_data | output | 256 | Wide output data |
| w_out_lv | output | 8 | Wide output per-lane valid |
| w_out_tag | output | 32 | Wide output per-lane tag |

## Verification
The bench builds the block with its default geometry: eight 32-bit wide lanes, four narrow lanes and 4-bit tags. Each lane gets a distinct data word and tag, so a swapped half, a shifted lane or a lost tag shows up directly. The beats use irregular valid masks, which exposes any per-lane valid bit that is dropped or duplicated. The default geometry also puts the half-rate split cadence, the pair-holding state of concatenation and mode changes in the middle of a unit of work within a few cycles of directed stimulus.

// File: rtl/lwc_pkg.sv
package lwc_pkg;

    parameter int unsigned LANE_W   = 32;
    parameter int unsigned TAG_W    = 4;
    parameter int unsigned WIDE_N   = 8;
    localparam int unsigned NARROW_N = WIDE_N / 2;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [LANE_W-1:0] data;
    } lane_t;

    typedef enum logic {
        NAR_SPLIT = 1'b0,
        NAR_TRIM  = 1'b1
    } nar_mode_e;

    typedef enum logic {
        WID_CONCAT = 1'b0,
        WID_PAD    = 1'b1
    } wid_mode_e;

    function automatic lane_t blank_lane();
        lane_t l;
        l = '0;
        return l;
    endfunction

endpackage

// File: rtl/lwc_narrow.sv
module lwc_narrow
    import lwc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  nar_mode_e                 mode,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  lane_t [WIDE_N-1:0]        in_lanes,
    output logic                      out_valid,
    input  logic                      out_ready,
    output lane_t [NARROW_N-1:0]      out_lanes
);

    lane_t [WIDE_N-1:0] hold_q;
    logic               full_q;
    logic               upper_q;
    nar_mode_e          mode_q;

    logic last_beat;
    logic out_fire;
    logic in_fire;

    assign last_beat = (mode_q == NAR_TRIM) || upper_q;
    assign out_fire  = full_q && out_ready;
    assign in_ready  = !full_q || (out_fire && last_beat);
    assign in_fire   = in_valid && in_ready;
    assign out_valid = full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            full_q  <= 1'b0;
            upper_q <= 1'b0;
            mode_q  <= NAR_SPLIT;
        end else if (in_fire) begin
            hold_q  <= in_lanes;
            mode_q  <= mode;
            full_q  <= 1'b1;
            upper_q <= 1'b0;
        end else if (out_fire) begin
            if (last_beat) begin
                full_q  <= 1'b0;
                upper_q <= 1'b0;
            end else begin
                upper_q <= 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NARROW_N; i++) begin : g_sel
        assign out_lanes[i] = upper_q ? hold_q[i + NARROW_N] : hold_q[i];
    end

    // R8: a blocked narrow beat must not change
    a_r8_nar_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_lanes)));

    // R4: input is refused while the lower half of a split is outstanding
    a_r4_split_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mode_q == NAR_SPLIT && !upper_q) |-> !in_ready);

    // R2: the lower half of a split is always followed by the upper half
    a_r2_split_second: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && mode_q == NAR_SPLIT && !upper_q) |=> out_valid);

    // R9: an accepted wide beat is visible on the next cycle
    a_r9_nar_latency: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

endmodule

// File: rtl/lwc_widen.sv
module lwc_widen
    import lwc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  wid_mode_e                 mode,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  lane_t [NARROW_N-1:0]      in_lanes,
    output logic                      out_valid,
    input  logic                      out_ready,
    output lane_t [WIDE_N-1:0]        out_lanes
);

    lane_t [NARROW_N-1:0] lo_q;
    logic                 lo_full_q;
    lane_t [WIDE_N-1:0]   out_q;
    logic                 out_full_q;

    lane_t [WIDE_N-1:0]   joined;
    logic                 take_first;
    logic                 slot_free;
    logic                 in_fire;
    logic [NARROW_N-1:0]  hi_vld;

    assign take_first = !lo_full_q && (mode == WID_CONCAT);
    assign slot_free  = !out_full_q || out_ready;
    assign in_ready   = take_first || slot_free;
    assign in_fire    = in_valid && in_ready;
    assign out_valid  = out_full_q;
    assign out_lanes  = out_q;

    for (genvar i = 0; i < NARROW_N; i++) begin : g_join
        assign joined[i]            = lo_full_q ? lo_q[i] : in_lanes[i];
        assign joined[i + NARROW_N] = lo_full_q ? in_lanes[i] : blank_lane();
        assign hi_vld[i]            = out_lanes[i + NARROW_N].vld;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q       <= '0;
            lo_full_q  <= 1'b0;
            out_q      <= '0;
            out_full_q <= 1'b0;
        end else begin
            if (out_full_q && out_ready) begin
                out_full_q <= 1'b0;
            end
            if (in_fire) begin
                if (take_first) begin
                    lo_q      <= in_lanes;
                    lo_full_q <= 1'b1;
                end else begin
                    out_q      <= joined;
                    out_full_q <= 1'b1;
                    lo_full_q  <= 1'b0;
                end
            end
        end
    end

    // R8: a blocked wide beat must not change
    a_r8_wid_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_lanes)));

    // R6: a padded beat leaves its upper lanes invalid
    a_r6_pad_invalid: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !lo_full_q && mode == WID_PAD)
        |=> (out_valid && $countones(hi_vld) == 0));

    // R5: the first half of a pair yields no output on its own
    a_r5_first_silent: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && take_first && !out_full_q) |=> !out_valid);

    // R9: a completing beat is visible on the next cycle
    a_r9_wid_latency: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !take_first) |=> out_valid);

endmodule

// File: rtl/lanewidth_conv.sv
module lanewidth_conv
    import lwc_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          nar_mode,
    input  logic                          w_in_valid,
    output logic                          w_in_ready,
    input  logic [WIDE_N*LANE_W-1:0]      w_in_data,
    input  logic [WIDE_N-1:0]             w_in_lv,
    input  logic [WIDE_N*TAG_W-1:0]       w_in_tag,
    output logic                          n_out_valid,
    input  logic                          n_out_ready,
    output logic [NARROW_N*LANE_W-1:0]    n_out_data,
    output logic [NARROW_N-1:0]           n_out_lv,
    output logic [NARROW_N*TAG_W-1:0]     n_out_tag,
    input  logic                          wid_mode,
    input  logic                          n_in_valid,
    output logic                          n_in_ready,
    input  logic [NARROW_N*LANE_W-1:0]    n_in_data,
    input  logic [NARROW_N-1:0]           n_in_lv,
    input  logic [NARROW_N*TAG_W-1:0]     n_in_tag,
    output logic                          w_out_valid,
    input  logic                          w_out_ready,
    output logic [WIDE_N*LANE_W-1:0]      w_out_data,
    output logic [WIDE_N-1:0]             w_out_lv,
    output logic [WIDE_N*TAG_W-1:0]       w_out_tag
);

    lane_t [WIDE_N-1:0]   w_in_lanes;
    lane_t [NARROW_N-1:0] n_out_lanes;
    lane_t [NARROW_N-1:0] n_in_lanes;
    lane_t [WIDE_N-1:0]   w_out_lanes;

    for (genvar i = 0; i < WIDE_N; i++) begin : g_wide
        assign w_in_lanes[i].data = w_in_data[i*LANE_W +: LANE_W];
        assign w_in_lanes[i].tag  = w_in_tag[i*TAG_W +: TAG_W];
        assign w_in_lanes[i].vld  = w_in_lv[i];
        assign w_out_data[i*LANE_W +: LANE_W] = w_out_lanes[i].data;
        assign w_out_tag[i*TAG_W +: TAG_W]    = w_out_lanes[i].tag;
        assign w_out_lv[i]                    = w_out_lanes[i].vld;
    end

    for (genvar i = 0; i < NARROW_N; i++) begin : g_narrow
        assign n_in_lanes[i].data = n_in_data[i*LANE_W +: LANE_W];
        assign n_in_lanes[i].tag  = n_in_tag[i*TAG_W +: TAG_W];
        assign n_in_lanes[i].vld  = n_in_lv[i];
        assign n_out_data[i*LANE_W +: LANE_W] = n_out_lanes[i].data;
        assign n_out_tag[i*TAG_W +: TAG_W]    = n_out_lanes[i].tag;
        assign n_out_lv[i]                    = n_out_lanes[i].vld;
    end

    lwc_narrow u_narrow (
        .clk       (clk),
        .rst       (rst),
        .mode      (nar_mode_e'(nar_mode)),
        .in_valid  (w_in_valid),
        .in_ready  (w_in_ready),
        .in_lanes  (w_in_lanes),
        .out_valid (n_out_valid),
        .out_ready (n_out_ready),
        .out_lanes (n_out_lanes)
    );

    lwc_widen u_widen (
        .clk       (clk),
        .rst       (rst),
        .mode      (wid_mode_e'(wid_mode)),
        .in_valid  (n_in_valid),
        .in_ready  (n_in_ready),
        .in_lanes  (n_in_lanes),
        .out_valid (w_out_valid),
        .out_ready (w_out_ready),
        .out_lanes (w_out_lanes)
    );

    // R1: both outputs are empty in the cycle after reset
    a_r1_reset_empty: assert property (@(posedge clk)
        rst |=> (!n_out_valid && !w_out_valid));

endmodule

// File: tb/test_lanewidth_conv.sv
module test_lanewidth_conv;

    logic         clk = 1'b0;
    logic         rst;
    logic         nar_mode;
    logic         w_in_valid;
    logic         w_in_ready;
    logic [255:0] w_in_data;
    logic [7:0]   w_in_lv;
    logic [31:0]  w_in_tag;
    logic         n_out_valid;
    logic         n_out_ready;
    logic [127:0] n_out_data;
    logic [3:0]   n_out_lv;
    logic [15:0]  n_out_tag;
    logic         wid_mode;
    logic         n_in_valid;
    logic         n_in_ready;
    logic [127:0] n_in_data;
    logic [3:0]   n_in_lv;
    logic [15:0]  n_in_tag;
    logic         w_out_valid;
    logic         w_out_ready;
    logic [255:0] w_out_data;
    logic [7:0]   w_out_lv;
    logic [31:0]  w_out_tag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lanewidth_conv i_lanewidth_conv (
        .clk(clk), .rst(rst), .nar_mode(nar_mode),
        .w_in_valid(w_in_valid), .w_in_ready(w_in_ready), .w_in_data(w_in_data),
        .w_in_lv(w_in_lv), .w_in_tag(w_in_tag),
        .n_out_valid(n_out_valid), .n_out_ready(n_out_ready), .n_out_data(n_out_data),
        .n_out_lv(n_out_lv), .n_out_tag(n_out_tag),
        .wid_mode(wid_mode), .n_in_valid(n_in_valid), .n_in_ready(n_in_ready),
        .n_in_data(n_in_data), .n_in_lv(n_in_lv), .n_in_tag(n_in_tag),
        .w_out_valid(w_out_valid), .w_out_ready(w_out_ready), .w_out_data(w_out_data),
        .w_out_lv(w_out_lv), .w_out_tag(w_out_tag)
    );

    task automatic chk(input string rq, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [255:0] wd(input logic [31:0] base);
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[i*32 +: 32] = base + 32'(i);
        return r;
    endfunction

    function automatic logic [31:0] wt(input logic [31:0] base);
        logic [31:0] r;
        for (int i = 0; i < 8; i++) r[i*4 +: 4] = 4'(base + 32'(i));
        return r;
    endfunction

    function automatic logic [127:0] nd(input logic [31:0] base, input int h);
        logic [127:0] r;
        for (int i = 0; i < 4; i++) r[i*32 +: 32] = base + 32'(h*4 + i);
        return r;
    endfunction

    function automatic logic [15:0] nt(input logic [31:0] base, input int h);
        logic [15:0] r;
        for (int i = 0; i < 4; i++) r[i*4 +: 4] = 4'(base + 32'(h*4 + i));
        return r;
    endfunction

    task automatic drive_wide(input logic [31:0] base, input logic [7:0] lv);
        w_in_valid = 1'b1;
        w_in_data  = wd(base);
        w_in_tag   = wt(base);
        w_in_lv    = lv;
    endtask

    task automatic drive_narrow(input logic [31:0] base, input logic [3:0] lv);
        n_in_valid = 1'b1;
        n_in_data  = nd(base, 0);
        n_in_tag   = nt(base, 0);
        n_in_lv    = lv;
    endtask

    task automatic t_reset;
        chk("R1 n_out_valid", 256'(n_out_valid), 256'd0);
        chk("R1 w_out_valid", 256'(w_out_valid), 256'd0);
        chk("R1 w_in_ready", 256'(w_in_ready), 256'd1);
        chk("R1 n_in_ready", 256'(n_in_ready), 256'd1);
    endtask

    task automatic t_split_single;
        n_out_ready = 1'b1;
        nar_mode    = 1'b0;
        drive_wide(32'h1000, 8'b1100_0101);
        @(negedge clk);
        w_in_valid = 1'b0;
        chk("R9 split first valid", 256'(n_out_valid), 256'd1);
        chk("R2 lower data", 256'(n_out_data), 256'(nd(32'h1000, 0)));
        chk("R2 lower tag", 256'(n_out_tag), 256'(nt(32'h1000, 0)));
        chk("R2 lower lv", 256'(n_out_lv), 256'h5);
        #1;
        chk("R4 ready low on lower half", 256'(w_in_ready), 256'd0);
        @(negedge clk);
        chk("R2 upper valid", 256'(n_out_valid), 256'd1);
        chk("R2 upper data", 256'(n_out_data), 256'(nd(32'h1000, 1)));
        chk("R2 upper tag", 256'(n_out_tag), 256'(nt(32'h1000, 1)));
        chk("R2 upper lv", 256'(n_out_lv), 256'hC);
        #1;
        chk("R4 ready high on upper half", 256'(w_in_ready), 256'd1);
        @(negedge clk);
        chk("R2 drained", 256'(n_out_valid), 256'd0);
    endtask

    task automatic t_narrow_stream(input logic trim);
        int k = 0;
        int e = 0;
        int acc = 0;
        int nbeats = 4;
        int cycles = trim ? 4 : 8;
        int nexp = trim ? nbeats : 2 * nbeats;
        n_out_ready = 1'b1;
        nar_mode    = trim;
        for (int c = 0; c < cycles + 4; c++) begin
            if (n_out_valid) begin
                int b = trim ? e : e / 2;
                int h = trim ? 0 : e % 2;
                logic [7:0] lv = 8'hA5 ^ 8'(b * 17);
                chk(trim ? "R3 trim data" : "R4 split stream data", 256'(n_out_data),
                    256'(nd(32'h2000 + 32'(b * 32'h100), h)));
                chk(trim ? "R3 trim lv" : "R2 split stream lv", 256'(n_out_lv),
                    256'(h == 1 ? lv[7:4] : lv[3:0]));
                e++;
            end
            if (k < nbeats) drive_wide(32'h2000 + 32'(k * 32'h100), 8'hA5 ^ 8'(k * 17));
            else w_in_valid = 1'b0;
            #1;
            if (w_in_valid && w_in_ready) begin
                k++;
                if (c < cycles) acc++;
            end
            @(negedge clk);
        end
        w_in_valid = 1'b0;
        chk(trim ? "R3 accepts per cycle" : "R4 accepts in window", 256'(acc),
            256'(trim ? cycles : cycles / 2));
        chk(trim ? "R3 beat count" : "R2 beat count", 256'(e), 256'(nexp));
    endtask

    task automatic t_narrow_stall;
        n_out_ready = 1'b0;
        nar_mode    = 1'b0;
        drive_wide(32'h3000, 8'hFF);
        @(negedge clk);
        w_in_valid = 1'b0;
        chk("R8 stalled lower", 256'(n_out_data), 256'(nd(32'h3000, 0)));
        drive_wide(32'h3800, 8'hFF);
        #1;
        chk("R8 input refused", 256'(w_in_ready), 256'd0);
        @(negedge clk);
        w_in_valid = 1'b0;
        chk("R8 still valid", 256'(n_out_valid), 256'd1);
        chk("R8 stable lower", 256'(n_out_data), 256'(nd(32'h3000, 0)));
        nar_mode    = 1'b1;
        n_out_ready = 1'b1;
        @(negedge clk);
        chk("R7 upper sent after mode change", 256'(n_out_data), 256'(nd(32'h3000, 1)));
        chk("R7 upper valid", 256'(n_out_valid), 256'd1);
        @(negedge clk);
        chk("R7 narrow drained", 256'(n_out_valid), 256'd0);
    endtask

    task automatic t_concat;
        w_out_ready = 1'b1;
        wid_mode    = 1'b0;
        drive_narrow(32'h4000, 4'b1001);
        @(negedge clk);
        chk("R5 no output after first", 256'(w_out_valid), 256'd0);
        drive_narrow(32'h4100, 4'b0110);
        @(negedge clk);
        n_in_valid = 1'b0;
        chk("R9 concat valid", 256'(w_out_valid), 256'd1);
        chk("R5 concat data", w_out_data, {nd(32'h4100, 0), nd(32'h4000, 0)});
        chk("R5 concat tag", 256'(w_out_tag), 256'({nt(32'h4100, 0), nt(32'h4000, 0)}));
        chk("R5 concat lv", 256'(w_out_lv), 256'h69);
        @(negedge clk);
        chk("R5 concat drained", 256'(w_out_valid), 256'd0);
    endtask

    task automatic t_pad;
        w_out_ready = 1'b1;
        wid_mode    = 1'b1;
        drive_narrow(32'h5000, 4'b1011);
        @(negedge clk);
        n_in_valid = 1'b0;
        chk("R6 pad valid", 256'(w_out_valid), 256'd1);
        chk("R6 pad data", w_out_data, {128'd0, nd(32'h5000, 0)});
        chk("R6 pad tag", 256'(w_out_tag), 256'({16'd0, nt(32'h5000, 0)}));
        chk("R6 pad lv", 256'(w_out_lv), 256'h0B);
        @(negedge clk);
    endtask

    task automatic t_widen_mode_change;
        w_out_ready = 1'b1;
        wid_mode    = 1'b0;
        drive_narrow(32'h6000, 4'hF);
        @(negedge clk);
        wid_mode = 1'b1;
        drive_narrow(32'h6100, 4'b0110);
        #1;
        chk("R7 second half accepted", 256'(n_in_ready), 256'd1);
        @(negedge clk);
        n_in_valid = 1'b0;
        chk("R7 pair completed data", w_out_data, {nd(32'h6100, 0), nd(32'h6000, 0)});
        chk("R7 pair completed lv", 256'(w_out_lv), 256'h6F);
        @(negedge clk);
    endtask

    task automatic t_widen_stall;
        w_out_ready = 1'b0;
        wid_mode    = 1'b1;
        drive_narrow(32'h7000, 4'hF);
        @(negedge clk);
        drive_narrow(32'h7100, 4'hF);
        #1;
        chk("R8 widen input refused", 256'(n_in_ready), 256'd0);
        @(negedge clk);
        n_in_valid = 1'b0;
        chk("R8 widen still valid", 256'(w_out_valid), 256'd1);
        chk("R8 widen stable", w_out_data, {128'd0, nd(32'h7000, 0)});
        w_out_ready = 1'b1;
        @(negedge clk);
        chk("R8 widen drained", 256'(w_out_valid), 256'd0);
    endtask

    initial begin
        rst = 1'b1;
        nar_mode = 1'b0; wid_mode = 1'b0;
        w_in_valid = 1'b0; w_in_data = '0; w_in_lv = '0; w_in_tag = '0;
        n_in_valid = 1'b0; n_in_data = '0; n_in_lv = '0; n_in_tag = '0;
        n_out_ready = 1'b0; w_out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        @(negedge clk);
        t_split_single();
        t_narrow_stream(1'b0);
        t_narrow_stream(1'b1);
        t_narrow_stall();
        t_concat();
        t_pad();
        t_widen_mode_change();
        t_widen_stall();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1..: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule